// File: doc/BRIEF.md
# Dual-Channel ADC Serial Readout Controller

This controller sits on the host side of a simultaneous-sampling, two-channel converter and runs its serial port. A request on `start` pulls chip select low. That falling edge starts a conversion in the converter. Chip select then stays low, with the serial clock parked, for a programmed number of system cycles. After that, the controller clocks out the result of the conversion that the previous frame started. When the frame ends, it presents both 16-bit channel words together with a one-cycle valid strobe.

The controller has two data layouts, chosen per frame:

- **Two-wire layout:** the two channels arrive together on two separate data lines over 16 clocks.
- **One-wire layout:** both channels arrive one after the other on the first data line over 32 clocks.

In the one-wire layout, the controller can also:

- split the 32 clocks into two bursts of 16, separated by a programmable idle gap, while chip select stays low;
- add one trailing clock that carries nothing.

A configuration word can be sent on the data-in line during any frame. For example, the word that switches the converter into its one-wire layout can be sent this way.

The state machine has five states:

- **IDLE:** chip select is high and a request is awaited.
- **CONV:** chip select is low and the conversion time is counted down.
- **BURST:** serial clocks are generated.
- **GAP:** chip select is low and the clock is paused between the two half-bursts.
- **QUIET:** chip select is high for the minimum time between frames.

The transitions are:

- **launch:** IDLE to CONV, on `start`.
- **conv_done:** CONV to BURST.
- **split:** BURST to GAP, after bit 16 in the one-wire layout when the gap is nonzero.
- **resume:** GAP to BURST.
- **frame_end:** BURST to QUIET, after the last bit.
- **rearm:** QUIET to IDLE.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: After reset, the ports hold these values: `adc_cs_n`=1, `adc_sclk`=1, `adc_din`=0, `res_valid`=0 and `busy`=0.
- R2: `start` is accepted in IDLE. The next edge drives `adc_cs_n` low, and at least `conv_cycles` system cycles pass before the first falling edge of `adc_sclk`.
- R3: `adc_sclk` rests high whenever chip select is high. Each bit begins on a falling edge, which launches `adc_din`, and is sampled on the following rising edge. Words are most significant bit first. Each clock half lasts `HALF_DIV` system cycles.
- R4: In the two-wire layout (`one_wire`=0), a frame has exactly 16 clocks. `res_a` is taken from `adc_sdoa` and `res_b` from `adc_sdob`.
- R5: In the one-wire layout (`one_wire`=1), a frame has 32 clocks on `adc_sdoa`. The first 16 bits are `res_a` and the next 16 are `res_b`.
- R6: With `extra_clk`=1 in the one-wire layout, a 33rd clock is issued. The bit sampled on that clock leaves `res_a` and `res_b` unchanged.
- R7: In the one-wire layout with `gap_cycles` nonzero, `adc_sclk` stays high for at least `gap_cycles`+`HALF_DIV` cycles between clock 16 and clock 17, with chip select held low. With `gap_cycles`=0, no high period inside the frame is longer than `HALF_DIV` cycles.
- R8: With `cfg_wr_en`=1, `adc_din` carries `cfg_word` MSB first over the first 16 clocks. Otherwise `adc_din` is 0. `adc_din` is 0 whenever chip select is high. The word 0xA100 places the converter in its one-wire layout starting with the next frame.
- R9: Each frame returns the conversion started by the previous frame's chip-select falling edge. The first frame after reset produces no `res_valid`. Every later frame produces exactly one `res_valid` pulse, in the cycle in which `adc_cs_n` rises.
- R10: `adc_cs_n` stays high for at least `quiet_cycles` system cycles before each chip-select falling edge.
- R11: `res_a` and `res_b` change only in a cycle with `res_valid`=1. `one_wire`, `extra_clk`, `gap_cycles` and `cfg_word` are sampled when `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, taken in IDLE |
| one_wire | input | 1 | Selects the one-wire layout for the frame |
| extra_clk | input | 1 | Adds a trailing empty clock in the one-wire layout |
| cfg_wr_en | input | 1 | Sends `cfg_word` on `adc_din` |
| cfg_word | input | WORD_W | Configuration word to send |
| conv_cycles | input | TMR_W | Conversion wait, in system cycles |
| gap_cycles | input | TMR_W | Pause between half-bursts, 0 for a continuous burst |
| quiet_cycles | input | TMR_W | Minimum chip-select high time |
| busy | output | 1 | High outside IDLE |
| res_valid | output | 1 | One-cycle strobe for new results |
| res_a | output | WORD_W | Channel A result |
| res_b | output | WORD_W | Channel B result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_din | output | 1 | Serial data to the converter |
| adc_sdoa | input | 1 | Converter data line A |
| adc_sdob | input | 1 | Converter data line B |

## Verification
Results are due in the cycle in which chip select rises, which is `HALF_DIV` cycles after the rising clock edge that samples the last bit. They carry the conversion from one frame earlier. The scoreboard therefore queues, at each launch, the pair converted by the previous launch, and the monitor pops that pair only on a `res_valid` seen at a falling system-clock edge. Clock counts, the conversion wait, the pause length and the chip-select high time are measured from the pins once the frame has closed. The mid-frame configuration bits are read back through the converter model's own capture of `adc_din`.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

    localparam int RD_WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_BURST,
        ST_GAP,
        ST_QUIET
    } rd_state_e;

endpackage

// File: rtl/adc_rdout_tmr.sv
// Loadable down-counter shared by the conversion, pause and quiet waits.
module adc_rdout_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/adc_rdout_shift.sv
// Capture shift register: two parallel words or one 2*WORD_W stream.
module adc_rdout_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              one_wire,
    input  logic              sdoa,
    input  logic              sdob,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b
);
    localparam int CNT_W = $clog2(2 * WORD_W + 1);
    localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(2 * WORD_W);
    localparam logic [CNT_W-1:0] LIM_TWO = CNT_W'(WORD_W);

    logic [CNT_W-1:0] taken;
    logic             room;

    assign room = taken < (one_wire ? LIM_ONE : LIM_TWO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken  <= '0;
            word_a <= '0;
            word_b <= '0;
        end else if (clear) begin
            taken  <= '0;
            word_a <= '0;
            word_b <= '0;
        end else if (sample && room) begin
            taken <= taken + CNT_W'(1);
            if (one_wire) begin
                {word_a, word_b} <= {word_a[WORD_W-2:0], word_b, sdoa};
            end else begin
                word_a <= {word_a[WORD_W-2:0], sdoa};
                word_b <= {word_b[WORD_W-2:0], sdob};
            end
        end
    end
endmodule

// File: rtl/adc_rdout_dser.sv
// Serializer for the data-in line, MSB first, zero fill after the word.
module adc_rdout_dser #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              clear,
    output logic              din
);
    logic [WORD_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            din  <= 1'b0;
        end else if (load) begin
            sreg <= load_word;
            din  <= 1'b0;
        end else if (clear) begin
            sreg <= '0;
            din  <= 1'b0;
        end else if (shift) begin
            din  <= sreg[WORD_W-1];
            sreg <= {sreg[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
    import adc_rdout_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int TMR_W    = 8,
    parameter int WORD_W   = RD_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              one_wire,
    input  logic              extra_clk,
    input  logic              cfg_wr_en,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [TMR_W-1:0]  conv_cycles,
    input  logic [TMR_W-1:0]  gap_cycles,
    input  logic [TMR_W-1:0]  quiet_cycles,
    output logic              busy,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_a,
    output logic [WORD_W-1:0] res_b,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_din,
    input  logic              adc_sdoa,
    input  logic              adc_sdob
);
    localparam int PH_W  = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
    localparam int BIT_W = $clog2(2 * WORD_W + 2);
    localparam logic [PH_W-1:0]  PH_MID  = PH_W'(HALF_DIV - 1);
    localparam logic [PH_W-1:0]  PH_END  = PH_W'(2 * HALF_DIV - 1);
    localparam logic [BIT_W-1:0] LAST_2W = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] LAST_1W = BIT_W'(2 * WORD_W - 1);
    localparam logic [BIT_W-1:0] LAST_X  = BIT_W'(2 * WORD_W);

    rd_state_e state, state_nx;

    logic              cs_n_q, sclk_q, primed;
    logic              one_wire_q, extra_q;
    logic [TMR_W-1:0]  gap_q;
    logic [PH_W-1:0]   phase;
    logic [BIT_W-1:0]  bit_idx;
    logic [BIT_W-1:0]  bit_last;
    logic              ph_mid, ph_end, at_last, at_split;

    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              frame_begin, frame_end, fall_go, sample;
    logic [WORD_W-1:0] sh_a, sh_b;

    assign ph_mid   = (phase == PH_MID);
    assign ph_end   = (phase == PH_END);
    assign bit_last = one_wire_q ? (extra_q ? LAST_X : LAST_1W) : LAST_2W;
    assign at_last  = (bit_idx == bit_last);
    assign at_split = one_wire_q && (gap_q != '0) && (bit_idx == LAST_2W);

    // Next-state and strobe decode.
    always_comb begin
        state_nx    = state;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        frame_begin = 1'b0;
        frame_end   = 1'b0;
        fall_go     = 1'b0;
        sample      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin            // launch
                    state_nx    = ST_CONV;
                    tmr_load    = 1'b1;
                    tmr_val     = conv_cycles;
                    frame_begin = 1'b1;
                end
            end
            ST_CONV: begin
                if (tmr_done) begin         // conv_done
                    state_nx = ST_BURST;
                    fall_go  = 1'b1;
                end
            end
            ST_BURST: begin
                sample = ph_mid;
                if (ph_end) begin
                    if (at_last) begin      // frame_end
                        state_nx  = ST_QUIET;
                        tmr_load  = 1'b1;
                        tmr_val   = quiet_cycles;
                        frame_end = 1'b1;
                    end else if (at_split) begin   // split
                        state_nx = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = gap_q;
                    end else begin
                        fall_go = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_done) begin         // resume
                    state_nx = ST_BURST;
                    fall_go  = 1'b1;
                end
            end
            ST_QUIET: begin
                if (tmr_done) begin         // rearm
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Pin, counter and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q     <= 1'b1;
            sclk_q     <= 1'b1;
            phase      <= '0;
            bit_idx    <= '0;
            one_wire_q <= 1'b0;
            extra_q    <= 1'b0;
            gap_q      <= '0;
            primed     <= 1'b0;
            res_valid  <= 1'b0;
            res_a      <= '0;
            res_b      <= '0;
        end else begin
            res_valid <= 1'b0;
            if (frame_begin) begin
                cs_n_q     <= 1'b0;
                one_wire_q <= one_wire;
                extra_q    <= extra_clk & one_wire;
                gap_q      <= gap_cycles;
            end
            if (fall_go) begin
                sclk_q  <= 1'b0;
                phase   <= '0;
                bit_idx <= (state == ST_CONV) ? '0 : bit_idx + BIT_W'(1);
            end else if (state == ST_BURST) begin
                phase <= phase + PH_W'(1);
                if (ph_mid) begin
                    sclk_q <= 1'b1;
                end
            end
            if (frame_end) begin
                cs_n_q <= 1'b1;
                primed <= 1'b1;
                if (primed) begin
                    res_valid <= 1'b1;
                    res_a     <= sh_a;
                    res_b     <= sh_b;
                end
            end
        end
    end

    adc_rdout_tmr #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    adc_rdout_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_begin),
        .sample   (sample),
        .one_wire (one_wire_q),
        .sdoa     (adc_sdoa),
        .sdob     (adc_sdob),
        .word_a   (sh_a),
        .word_b   (sh_b)
    );

    adc_rdout_dser #(.WORD_W(WORD_W)) u_dser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_begin),
        .load_word (cfg_wr_en ? cfg_word : '0),
        .shift     (fall_go),
        .clear     (frame_end),
        .din       (adc_din)
    );

    assign busy     = (state != ST_IDLE);
    assign adc_cs_n = cs_n_q;
    assign adc_sclk = sclk_q;
endmodule

// File: rtl/adc_rdout_chk.sv
module adc_rdout_chk #(
    parameter int WORD_W = 16,
    parameter int TMR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sclk,
    input logic              din,
    input logic              res_valid,
    input logic [WORD_W-1:0] res_a,
    input logic [WORD_W-1:0] res_b,
    input logic [TMR_W-1:0]  conv_cycles,
    input logic [TMR_W-1:0]  quiet_cycles
);
    localparam int SAT_W = TMR_W + 2;
    localparam logic [SAT_W-1:0] SAT_MAX = '1;

    logic [SAT_W-1:0] lo_cnt, hi_cnt;
    logic [6:0]       fall_cnt;
    logic [1:0]       frames;
    logic             sclk_d, cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt   <= '0;
            hi_cnt   <= SAT_MAX;
            fall_cnt <= '0;
            frames   <= '0;
            sclk_d   <= 1'b1;
            cs_d     <= 1'b1;
        end else begin
            sclk_d   <= sclk;
            cs_d     <= cs_n;
            lo_cnt   <= cs_n ? '0 : ((lo_cnt == SAT_MAX) ? lo_cnt : lo_cnt + SAT_W'(1));
            hi_cnt   <= !cs_n ? '0 : ((hi_cnt == SAT_MAX) ? hi_cnt : hi_cnt + SAT_W'(1));
            fall_cnt <= cs_n ? '0 : fall_cnt + 7'(sclk_d & ~sclk);
            if (cs_n && !cs_d && frames != 2'd3) begin
                frames <= frames + 2'd1;
            end
        end
    end

    // R2: first clock edge only after the conversion wait
    a_r2_conv_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (lo_cnt >= SAT_W'(conv_cycles)));

    // R3: clock parked high outside a frame
    a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R4, R5, R6: legal clock counts per frame
    a_r4_clock_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (fall_cnt == 7'd16 || fall_cnt == 7'd32 || fall_cnt == 7'd33));

    // R8: data-in quiet outside a frame
    a_r8_din_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !din);

    // R9: strobe coincides with chip select release
    a_r9_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(cs_n));

    // R9: no strobe before a frame has completed
    a_r9_no_first_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (frames != 2'd0));

    // R10: minimum high time before each launch
    a_r10_quiet_time: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= SAT_W'(quiet_cycles)));

    // R11: results hold between strobes
    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_a) && $stable(res_b)));
endmodule

bind adc_rdout_ctrl adc_rdout_chk #(.WORD_W(WORD_W), .TMR_W(TMR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (adc_cs_n),
    .sclk         (adc_sclk),
    .din          (adc_din),
    .res_valid    (res_valid),
    .res_a        (res_a),
    .res_b        (res_b),
    .conv_cycles  (conv_cycles),
    .quiet_cycles (quiet_cycles)
);

// File: tb/adc_rdout_ctrl_tb.sv
`timescale 1ns/1ps
module adc_rdout_ctrl_tb;
    localparam int HALF  = 2;
    localparam int TW    = 8;
    localparam int W     = 16;
    localparam int CONV  = 40;
    localparam int QUIET = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          start = 0, one_wire = 0, extra_clk = 0, cfg_wr_en = 0;
    logic [W-1:0]  cfg_word = '0;
    logic [TW-1:0] conv_cycles = TW'(CONV), gap_cycles = '0, quiet_cycles = TW'(QUIET);
    logic          busy, res_valid, adc_cs_n, adc_sclk, adc_din;
    logic [W-1:0]  res_a, res_b;
    logic          adc_sdoa = 0, adc_sdob = 0;

    adc_rdout_ctrl #(.HALF_DIV(HALF), .TMR_W(TW), .WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .one_wire(one_wire),
        .extra_clk(extra_clk), .cfg_wr_en(cfg_wr_en), .cfg_word(cfg_word),
        .conv_cycles(conv_cycles), .gap_cycles(gap_cycles), .quiet_cycles(quiet_cycles),
        .busy(busy), .res_valid(res_valid), .res_a(res_a), .res_b(res_b),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
        .adc_sdoa(adc_sdoa), .adc_sdob(adc_sdob)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] val_a(input int k);
        return 16'(32'hA5C3 ^ (k * 32'h1357));
    endfunction
    function automatic logic [W-1:0] val_b(input int k);
        return 16'(32'h3C5A + k * 32'h0BD1);
    endfunction

    // Converter model: conversion on CS fall, one-frame latency.
    bit           adc_1w = 0;
    logic [W-1:0] pend_a = '0, pend_b = '0, out_a = '0, out_b = '0, din_cap = '0;
    int           conv_k = 0, sh_idx = 0, din_n = 0, last_falls = 0;
    logic [W-1:0] last_din = '0;

    always @(negedge adc_cs_n) begin
        out_a  = pend_a;
        out_b  = pend_b;
        pend_a = val_a(conv_k);
        pend_b = val_b(conv_k);
        conv_k++;
        sh_idx = 0;
        din_n  = 0;
        din_cap = '0;
    end

    always @(negedge adc_sclk) begin
        if (!adc_cs_n) begin
            if (adc_1w) begin
                adc_sdoa = (sh_idx < 16) ? out_a[15 - sh_idx] :
                           (sh_idx < 32) ? out_b[31 - sh_idx] : 1'b0;
                adc_sdob = 1'b0;
            end else begin
                adc_sdoa = (sh_idx < 16) ? out_a[15 - sh_idx] : 1'b0;
                adc_sdob = (sh_idx < 16) ? out_b[15 - sh_idx] : 1'b0;
            end
            sh_idx++;
        end
    end

    always @(posedge adc_sclk) begin
        if (!adc_cs_n && din_n < 16) begin
            din_cap = {din_cap[14:0], adc_din};
            din_n++;
        end
    end

    always @(posedge adc_cs_n) begin
        last_falls = sh_idx;
        last_din   = din_cap;
        if (din_n == 16 && din_cap == 16'hA100) adc_1w = 1;
    end

    // Pin timing measurement at the falling system-clock edge.
    int  lo_cnt = 0, hi_cnt = 0, conv_meas = 0, quiet_meas = 0, hi_run = 0, max_hi = 0;
    bit  prev_cs = 1, prev_sclk = 1, seen_fall = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!adc_cs_n) begin
                if (prev_cs) begin
                    lo_cnt = 0; seen_fall = 0; hi_run = 0; max_hi = 0;
                    quiet_meas = hi_cnt;
                end
                lo_cnt++;
                if (prev_sclk && !adc_sclk && !seen_fall) begin
                    seen_fall = 1;
                    conv_meas = lo_cnt;
                end
                if (seen_fall) begin
                    if (adc_sclk) hi_run++;
                    else begin
                        if (hi_run > max_hi) max_hi = hi_run;
                        hi_run = 0;
                    end
                end
            end else begin
                if (!prev_cs) hi_cnt = 0;
                hi_cnt++;
            end
            prev_cs   = adc_cs_n;
            prev_sclk = adc_sclk;
        end
    end

    // Scoreboard.
    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        string        tag;
    } exp_t;
    exp_t exp_q[$];
    int   valid_cnt = 0, drift = 0;
    logic [W-1:0] held_a = '0, held_b = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                valid_cnt++;
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected result strobe", 32'(valid_cnt), 32'(0));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(res_a == e.a, e.tag, "channel A word", 32'(res_a), 32'(e.a));
                    chk(res_b == e.b, e.tag, "channel B word", 32'(res_b), 32'(e.b));
                end
                held_a = res_a;
                held_b = res_b;
            end else if (res_a !== held_a || res_b !== held_b) begin
                drift++;
            end
        end
    end

    int frame_no = 0;

    task automatic run_frame(input bit ow, input bit ex, input bit cw,
                             input logic [W-1:0] cwd, input int gap);
        int exp_clk;
        string tag;
        @(negedge clk);
        while (busy) @(negedge clk);
        one_wire   = ow;
        extra_clk  = ex;
        cfg_wr_en  = cw;
        cfg_word   = cwd;
        gap_cycles = TW'(gap);
        tag = ow ? (ex ? "R6" : "R5") : "R4";
        if (frame_no > 0) exp_q.push_back('{val_a(frame_no - 1), val_b(frame_no - 1), tag});
        start = 1;
        @(negedge clk);
        start = 0;
        cfg_word = 16'hFFFF;           // R11: later changes must not reach the pin
        gap_cycles = TW'(0);
        @(negedge clk);
        while (busy) @(negedge clk);
        exp_clk = ow ? (ex ? 33 : 32) : 16;
        chk(last_falls == exp_clk, tag, "clock count", 32'(last_falls), 32'(exp_clk));
        chk(last_din == (cw ? cwd : 16'h0000), "R8", "data-in word",
            32'(last_din), 32'(cw ? cwd : 16'h0000));
        chk(conv_meas >= CONV + 1, "R2", "conversion wait", 32'(conv_meas), 32'(CONV + 1));
        if (ow) begin
            if (gap == 0)
                chk(max_hi == HALF, "R7", "continuous burst high time", 32'(max_hi), 32'(HALF));
            else
                chk(max_hi >= gap + HALF, "R7", "pause length", 32'(max_hi), 32'(gap + HALF));
        end
        if (frame_no > 0)
            chk(quiet_meas >= QUIET, "R10", "chip select high time", 32'(quiet_meas), 32'(QUIET));
        if (frame_no == 0)
            chk(valid_cnt == 0, "R9", "first frame strobe count", 32'(valid_cnt), 32'(0));
        frame_no++;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(adc_cs_n == 1'b1, "R1", "cs_n after reset", 32'(adc_cs_n), 32'(1));
        chk(adc_sclk == 1'b1, "R1", "sclk after reset", 32'(adc_sclk), 32'(1));
        chk(adc_din == 1'b0, "R1", "din after reset", 32'(adc_din), 32'(0));
        chk(res_valid == 1'b0, "R1", "valid after reset", 32'(res_valid), 32'(0));
        chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'(0));

        run_frame(0, 0, 0, 16'h0000, 0);   // no data expected
        run_frame(0, 0, 1, 16'h1234, 0);   // R8 other word, layout unchanged
        run_frame(0, 0, 1, 16'hA100, 0);   // R8 switch to one-wire
        run_frame(1, 0, 0, 16'h0000, 0);   // R5 continuous
        run_frame(1, 0, 0, 16'h0000, 5);   // R7 split burst
        run_frame(1, 1, 0, 16'h0000, 0);   // R6 trailing clock
        run_frame(1, 1, 1, 16'h5A0F, 7);   // R6, R7, R8 combined
        run_frame(1, 0, 0, 16'h0000, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "results outstanding", 32'(exp_q.size()), 32'(0));
        chk(valid_cnt == frame_no - 1, "R9", "strobe count", 32'(valid_cnt), 32'(frame_no - 1));
        chk(drift == 0, "R11", "result change without strobe", 32'(drift), 32'(0));
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", frame_no, 8);
            summary();
            $finish;
        end
    end
endmodule